// File: doc/BRIEF.md
# DRAM Multiplexed Address Controller with Row Refresh

This block is the access front end and refresh sequencer for a one-bit-wide dynamic memory. The cell array has 2^ADDR_W rows and 2^ADDR_W columns. With the default ADDR_W of 8 this gives 256 x 256 cells, or 65536 one-bit words. The array is modelled inside the block. The host supplies the address in two halves over one narrow bus:

- A falling row strobe loads the bus into a row register.
- A later falling column strobe loads the bus into a column register and starts a single-bit read or write.

Both strobes are active low. One data-in line, one data-out line and one write-enable line carry the transfer.

Beside the host path, a refresh walker schedules one row refresh every REF_INTERVAL clock cycles. It visits rows in ascending order and wraps at the top. Arbitration between the two paths works as follows:

- A refresh never interrupts a host access. Requests that come due while a strobe is low are counted and run back to back once both strobes are high again.
- While a refresh runs, `ready` is held low. A host access begun in that window is not accepted.

The retention deadline is the cycle count REF_PERIOD. If the row next in line has gone longer than REF_PERIOD cycles without a refresh, a sticky error flag is raised.

Top module: `dram_mux_ctrl`

## Requirements
- R1: A clock edge at which `row_stb_n` is sampled 0, after being sampled 1 at the previous edge, loads `addr_i` into the row register, provided `ready` is 1. The row register then holds that value until the next accepted row fall, whatever `addr_i` does.
- R2: The access is a column fall (`col_stb_n` sampled 0 after 1) while `row_stb_n` is low and a row was accepted at an earlier edge. It loads `addr_i` into the column register and acts on cell (row, column) one edge later. With `we_n`=1 it is a read, and the cell value appears on `dout` after that second edge. With `we_n`=0 it is a write, and the cell takes `din` as sampled at the column fall.
- R3: A column fall has no effect on the array or on `dout` when `row_stb_n` is high, or when it coincides with the row fall.
- R4: A write leaves `dout` unchanged.
- R5: While `row_stb_n` stays low, any number of further column falls each perform an access in the same captured row.
- R6: A refresh request arises every REF_INTERVAL cycles. When one is pending and both strobes are sampled high, a refresh starts, and `ready` is 0 for exactly REF_CYCLES cycles. While idle, consecutive refresh starts are REF_INTERVAL cycles apart.
- R7: `refresh_row` shows the row being refreshed. The first refresh after reset is row 0, and each later refresh is the previous row plus one, wrapping from 2^ADDR_W-1 to 0.
- R8: No refresh starts while either strobe is low; `ready` stays 1 throughout a host access. Requests are counted up to 2^PEND_W-1 and are served back to back once both strobes are high, in consecutive row order.
- R9: A row fall sampled while `ready` is 0 is not accepted. A column fall that follows it without a new accepted row fall performs no access.
- R10: Refresh never changes stored data.
- R11: `refresh_err` goes to 1 once the next row due for refresh has gone more than REF_PERIOD cycles without one; reset counts as a refresh of every row. The flag stays 1 until reset and stays 0 while refresh keeps pace.
- R12: After reset, `ready`=1, `dout`=0, `refresh_err`=0 and `refresh_row` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Shared row/column address bus |
| row_stb_n | input | 1 | Row strobe, active low |
| col_stb_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | 0 = write, 1 = read, sampled at the column fall |
| din | input | 1 | Write data |
| dout | output | 1 | Read data, held between reads |
| ready | output | 1 | 0 while a refresh occupies the array |
| refresh_row | output | ADDR_W | Row of the current or most recent refresh |
| refresh_err | output | 1 | Sticky retention-deadline violation |

## Verification
The bench changes `addr_i` between the row and column strobes, runs several columns under one row strobe, and reads back cells in different rows. A design that latched the row continuously, or reused a stale row, would return data from the wrong row.

It drops both strobes in the same cycle, pulses the column strobe with the row strobe high, and starts an access inside a refresh window. A controller that accepted any of these would overwrite a cell or change `dout`.

It holds a row strobe across several refresh intervals and checks three things:
- `ready` never drops during the hold.
- The backlog then runs in consecutive rows.
- A long hold sets the deadline flag, which then survives the catch-up refreshes.

It also follows more than one full lap of refreshes to catch a walker that skips, repeats or fails to wrap its row counter.

// File: rtl/dram_mux_pkg.sv
package dram_mux_pkg;

   // One column access handed from the strobe front end to the cell array
   typedef struct packed {
      logic fire;   // access occurs this cycle
      logic write;  // 1 = store data, 0 = fetch
      logic data;   // value to store
   } access_t;

   // Width of the cycle clock used for refresh time stamps
   function automatic int stamp_width(input int period);
      return $clog2(period) + 2;
   endfunction

endpackage

// File: rtl/dram_strobe_front.sv
module dram_strobe_front
   import dram_mux_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              row_stb_n,
   input  logic              col_stb_n,
   input  logic              we_n,
   input  logic              din,
   input  logic              ref_busy,
   output logic [ADDR_W-1:0] row_q,
   output logic [ADDR_W-1:0] col_q,
   output access_t           acc_q
);

   logic row_prev_q, col_prev_q;
   logic open_q;
   logic row_fall, col_fall, row_take, col_go;

   assign row_fall = row_prev_q & ~row_stb_n;
   assign col_fall = col_prev_q & ~col_stb_n;
   assign row_take = row_fall & ~ref_busy;
   assign col_go   = col_fall & open_q & ~row_stb_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_prev_q <= 1'b1;
         col_prev_q <= 1'b1;
      end else begin
         row_prev_q <= row_stb_n;
         col_prev_q <= col_stb_n;
      end
   end

   // Row window: opened by an accepted fall, closed when the strobe returns high
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         row_q  <= '0;
      end else begin
         if (row_stb_n)     open_q <= 1'b0;
         else if (row_take) open_q <= 1'b1;
         if (row_take)      row_q  <= addr_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q <= '0;
         acc_q <= '0;
      end else begin
         acc_q.fire <= col_go;
         if (col_go) begin
            col_q       <= addr_i;
            acc_q.write <= ~we_n;
            acc_q.data  <= din;
         end
      end
   end

   AST_ACCESS_UNDER_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q.fire |-> $past(!row_stb_n) && $past(open_q)); // R2
   AST_NO_OPEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(open_q) |-> $past(!ref_busy)); // R9
   AST_ROW_HELD_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (open_q && !row_stb_n) |=> $stable(row_q)); // R1

endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array
   import dram_mux_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  access_t           acc,
   input  logic [ADDR_W-1:0] row_i,
   input  logic [ADDR_W-1:0] col_i,
   output logic              dout
);

   localparam int ROWS = 1 << ADDR_W;
   localparam int COLS = 1 << ADDR_W;

   // One packed word per row; a column selects a bit of it
   logic [COLS-1:0] cells_q [ROWS];

   always_ff @(posedge clk) begin
      if (acc.fire && acc.write)
         cells_q[row_i][col_i] <= acc.data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dout <= 1'b0;
      else if (acc.fire && !acc.write)
         dout <= cells_q[row_i][col_i];
   end

   AST_WRITE_KEEPS_DOUT: assert property (@(posedge clk) disable iff (!rst_n)
      (acc.fire && acc.write) |=> $stable(dout)); // R4

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
   import dram_mux_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int REF_PERIOD   = 4096,
   parameter int REF_INTERVAL = 14,
   parameter int REF_CYCLES   = 2,
   parameter int PEND_W       = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobes_idle,
   output logic              busy,
   output logic [ADDR_W-1:0] ref_row_q,
   output logic              err_q
);

   localparam int ROWS = 1 << ADDR_W;
   localparam int TW   = stamp_width(REF_PERIOD);
   localparam int IW   = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;
   localparam logic [PEND_W-1:0] PEND_MAX = '1;
   localparam logic [TW-1:0]     LIMIT    = TW'(REF_PERIOD);
   localparam logic [IW-1:0]     TICK_END = IW'(REF_INTERVAL - 1);

   logic [IW-1:0]     tick_q;
   logic              tick;
   logic [PEND_W-1:0] pend_q;
   logic              start;
   logic [ADDR_W-1:0] ptr_q;
   logic [TW-1:0]     now_q;
   logic [TW-1:0]     stamp_q [ROWS];
   logic [TW-1:0]     age;

   assign tick  = (tick_q == TICK_END);
   assign start = (pend_q != '0) & ~busy & strobes_idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tick_q <= '0;
      else        tick_q <= tick ? '0 : tick_q + 1'b1;
   end

   // Backlog of refresh requests, saturating
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else begin
         case ({tick && (pend_q != PEND_MAX), start})
            2'b10:   pend_q <= pend_q + 1'b1;
            2'b01:   pend_q <= pend_q - 1'b1;
            default: pend_q <= pend_q;
         endcase
      end
   end

   generate
      if (REF_CYCLES == 1) begin : g_busy_flop
         logic busy_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) busy_q <= 1'b0;
            else        busy_q <= start;
         end
         assign busy = busy_q;
      end else begin : g_busy_cnt
         localparam int BW = $clog2(REF_CYCLES + 1);
         logic [BW-1:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              left_q <= '0;
            else if (start)          left_q <= BW'(REF_CYCLES);
            else if (left_q != '0)   left_q <= left_q - 1'b1;
         end
         assign busy = (left_q != '0);
         AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            left_q <= BW'(REF_CYCLES)); // R6
      end
   endgenerate

   // Row walker and per-row refresh time stamps
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q     <= '0;
         ref_row_q <= '1;
         now_q     <= '0;
         for (int i = 0; i < ROWS; i++) stamp_q[i] <= '0;
      end else begin
         now_q <= now_q + 1'b1;
         if (start) begin
            ref_row_q      <= ptr_q;
            ptr_q          <= ptr_q + 1'b1;
            stamp_q[ptr_q] <= now_q;
         end
      end
   end

   // Rows are visited in order, so the next one due is always the oldest
   assign age = now_q - stamp_q[ptr_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          err_q <= 1'b0;
      else if (age > LIMIT) err_q <= 1'b1;
   end

   AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> ref_row_q == ADDR_W'($past(ref_row_q) + 1'b1)); // R7
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q); // R11
   AST_PEND_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q == PEND_MAX) |=> (pend_q >= PEND_MAX - 1'b1)); // R8

endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl
   import dram_mux_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int REF_PERIOD   = 4096,
   parameter int REF_INTERVAL = 14,
   parameter int REF_CYCLES   = 2,
   parameter int PEND_W       = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              row_stb_n,
   input  logic              col_stb_n,
   input  logic              we_n,
   input  logic              din,
   output logic              dout,
   output logic              ready,
   output logic [ADDR_W-1:0] refresh_row,
   output logic              refresh_err
);

   localparam int ROWS = 1 << ADDR_W;

   generate
      if (ADDR_W < 2 || ADDR_W > 10) begin : g_bad_addr
         $error("ADDR_W must lie in 2..10");
      end
      if (REF_CYCLES < 1) begin : g_bad_cycles
         $error("REF_CYCLES must be at least 1");
      end
      if (REF_INTERVAL <= REF_CYCLES + 1) begin : g_bad_interval
         $error("REF_INTERVAL must exceed REF_CYCLES + 1");
      end
      if (REF_INTERVAL * ROWS >= REF_PERIOD) begin : g_bad_period
         $error("a full refresh lap must fit inside REF_PERIOD");
      end
      if (PEND_W < 1 || PEND_W > 8) begin : g_bad_pend
         $error("PEND_W must lie in 1..8");
      end
   endgenerate

   logic              ref_busy;
   logic [ADDR_W-1:0] row_q, col_q;
   access_t           acc;

   dram_strobe_front #(.ADDR_W(ADDR_W)) u_front (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
      .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
      .we_n(we_n), .din(din), .ref_busy(ref_busy),
      .row_q(row_q), .col_q(col_q), .acc_q(acc)
   );

   dram_cell_array #(.ADDR_W(ADDR_W)) u_array (
      .clk(clk), .rst_n(rst_n), .acc(acc),
      .row_i(row_q), .col_i(col_q), .dout(dout)
   );

   dram_refresh_seq #(
      .ADDR_W(ADDR_W), .REF_PERIOD(REF_PERIOD), .REF_INTERVAL(REF_INTERVAL),
      .REF_CYCLES(REF_CYCLES), .PEND_W(PEND_W)
   ) u_refresh (
      .clk(clk), .rst_n(rst_n),
      .strobes_idle(row_stb_n & col_stb_n),
      .busy(ref_busy), .ref_row_q(refresh_row), .err_q(refresh_err)
   );

   assign ready = ~ref_busy;

   AST_REF_WAITS_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready) |-> $past(row_stb_n && col_stb_n)); // R8
   AST_NO_ACCESS_IN_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
      acc.fire |-> ready); // R9

endmodule

// File: tb/dram_mux_ctrl_test.sv
module dram_mux_ctrl_test;

   localparam int CLK_PERIOD   = 10;
   localparam int ADDR_W       = 8;
   localparam int REF_PERIOD   = 4096;
   localparam int REF_INTERVAL = 14;
   localparam int REF_CYCLES   = 2;
   localparam int PEND_W       = 4;
   localparam int ROWS         = 1 << ADDR_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] addr_i = '0;
   logic              row_stb_n = 1'b1;
   logic              col_stb_n = 1'b1;
   logic              we_n = 1'b1;
   logic              din = 1'b0;
   logic              dout, ready, refresh_err;
   logic [ADDR_W-1:0] refresh_row;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dram_mux_ctrl #(
      .ADDR_W(ADDR_W), .REF_PERIOD(REF_PERIOD), .REF_INTERVAL(REF_INTERVAL),
      .REF_CYCLES(REF_CYCLES), .PEND_W(PEND_W)
   ) uut (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
      .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
      .we_n(we_n), .din(din), .dout(dout), .ready(ready),
      .refresh_row(refresh_row), .refresh_err(refresh_err)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wait_ready();
      while (!ready) @(negedge clk);
   endtask

   task automatic row_open(input int r);
      wait_ready();
      addr_i = ADDR_W'(r);
      row_stb_n = 1'b0;
      @(negedge clk);
   endtask

   task automatic row_close();
      row_stb_n = 1'b1;
      @(negedge clk);
   endtask

   // One column pulse; rd returns dout two edges after the fall
   task automatic col_pulse(input int c, input bit wr, input bit d, output bit rd);
      addr_i = ADDR_W'(c);
      we_n = ~wr;
      din = d;
      col_stb_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rd = dout;
      col_stb_n = 1'b1;
      we_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic host_write(input int r, input int c, input bit d);
      bit unused;
      row_open(r);
      col_pulse(c, 1'b1, d, unused);
      row_close();
   endtask

   task automatic host_read(input int r, input int c, output bit d);
      row_open(r);
      col_pulse(c, 1'b0, 1'b0, d);
      row_close();
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      row_stb_n = 1'b1;
      col_stb_n = 1'b1;
      we_n = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic test_reset_state();
      chk("R12 ready after reset", int'(ready), 1);
      chk("R12 dout after reset", int'(dout), 0);
      chk("R12 err after reset", int'(refresh_err), 0);
      chk("R12 refresh_row after reset", int'(refresh_row), ROWS - 1);
   endtask

   // Idle lap: order, wrap, spacing and length of refreshes
   task automatic test_refresh_lap();
      bit prev = 1'b1;
      int idx = 0, low_len = 0, last_start = -1, bad_row = 0, bad_gap = 0, bad_len = 0;
      for (int cyc = 0; cyc < 4300; cyc++) begin
         @(negedge clk);
         if (prev && !ready) begin
            if (int'(refresh_row) != idx % ROWS) bad_row++;
            if (last_start >= 0 && cyc - last_start != REF_INTERVAL) bad_gap++;
            last_start = cyc;
            idx++;
            low_len = 0;
         end
         if (!ready) low_len++;
         if (!prev && ready && low_len != REF_CYCLES) bad_len++;
         prev = ready;
      end
      chk("R7 rows out of order (incl. wrap)", bad_row, 0);
      chk("R7 lap passed wrap point", int'(idx > ROWS), 1);
      chk("R6 start spacing errors", bad_gap, 0);
      chk("R6 busy length errors", bad_len, 0);
      chk("R11 no error while refresh keeps pace", int'(refresh_err), 0);
   endtask

   task automatic test_basic_access();
      bit d;
      host_write(8'h00, 8'h00, 1'b1);
      host_write(8'hFF, 8'hFF, 1'b1);
      host_write(8'hFF, 8'h00, 1'b0);
      host_read(8'h00, 8'h00, d); chk("R2 read (00,00)", int'(d), 1);
      host_read(8'hFF, 8'h00, d); chk("R2 read (FF,00)", int'(d), 0);
      host_read(8'hFF, 8'hFF, d); chk("R2 read (FF,FF)", int'(d), 1);
      host_write(8'h80, 8'h80, 1'b0);
      chk("R4 write keeps dout", int'(dout), 1);
   endtask

   // Row held while the bus carries other values
   task automatic test_row_latch();
      bit d, unused;
      host_write(8'h34, 8'h07, 1'b0);
      row_open(8'h12);
      addr_i = 8'h34;
      @(negedge clk);
      col_pulse(8'h07, 1'b1, 1'b1, unused);
      row_close();
      host_read(8'h12, 8'h07, d); chk("R1 captured row written", int'(d), 1);
      host_read(8'h34, 8'h07, d); chk("R1 bus row untouched", int'(d), 0);
   endtask

   task automatic test_page_mode();
      bit d0, d1, d2, unused;
      row_open(8'h5A);
      col_pulse(8'h01, 1'b1, 1'b1, unused);
      col_pulse(8'h02, 1'b1, 1'b0, unused);
      col_pulse(8'hA5, 1'b1, 1'b1, unused);
      col_pulse(8'h01, 1'b0, 1'b0, d0);
      col_pulse(8'h02, 1'b0, 1'b0, d1);
      col_pulse(8'hA5, 1'b0, 1'b0, d2);
      row_close();
      chk("R5 page col 01", int'(d0), 1);
      chk("R5 page col 02", int'(d1), 0);
      chk("R5 page col A5", int'(d2), 1);
   endtask

   task automatic test_bad_order();
      bit d;
      host_write(8'h41, 8'h41, 1'b0);
      host_read(8'h00, 8'h00, d);
      // both strobes in the same cycle, read of a 0 cell
      wait_ready();
      addr_i = 8'h41; we_n = 1'b1;
      row_stb_n = 1'b0; col_stb_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R3 simultaneous fall: dout kept", int'(dout), 1);
      row_stb_n = 1'b1; col_stb_n = 1'b1;
      @(negedge clk);
      // column alone writes nothing
      addr_i = 8'h41; we_n = 1'b0; din = 1'b1; col_stb_n = 1'b0;
      repeat (3) @(negedge clk);
      col_stb_n = 1'b1; we_n = 1'b1;
      @(negedge clk);
      host_read(8'h41, 8'h41, d);
      chk("R3 column with row high wrote nothing", int'(d), 0);
   endtask

   task automatic test_refresh_stall();
      bit d;
      int guard = 0;
      host_write(8'h40, 8'h40, 1'b1);
      host_read(8'h40, 8'h40, d);
      while (ready && guard < 100) begin @(negedge clk); guard++; end
      chk("R9 refresh window seen", int'(ready), 0);
      addr_i = 8'h41; row_stb_n = 1'b0;
      @(negedge clk);
      we_n = 1'b1; col_stb_n = 1'b0;
      repeat (4) @(negedge clk);
      chk("R9 access in refresh window ignored", int'(dout), 1);
      row_stb_n = 1'b1; col_stb_n = 1'b1;
      @(negedge clk);
      host_read(8'h41, 8'h41, d);
      chk("R9 target cell really holds 0", int'(d), 0);
   endtask

   task automatic test_deferral();
      int lows = 0, first, count, bad = 0;
      bit prev;
      row_open(8'h33);
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (!ready) lows++;
      end
      chk("R8 ready held during host access", lows, 0);
      row_close();
      chk("R8 refresh starts once strobes high", int'(ready), 0);
      first = int'(refresh_row);
      count = 1;
      prev = ready;
      for (int i = 0; i < 9; i++) begin
         @(negedge clk);
         if (prev && !ready) begin
            if (int'(refresh_row) != (first + count) % ROWS) bad++;
            count++;
         end
         prev = ready;
      end
      chk("R8 backlog served back to back", int'(count >= 2), 1);
      chk("R8 backlog rows consecutive", bad, 0);
   endtask

   task automatic test_retention();
      bit d;
      repeat (600) @(negedge clk);
      host_read(8'h00, 8'h00, d); chk("R10 (00,00) kept", int'(d), 1);
      host_read(8'hFF, 8'h00, d); chk("R10 (FF,00) kept", int'(d), 0);
      host_read(8'h5A, 8'hA5, d); chk("R10 (5A,A5) kept", int'(d), 1);
   endtask

   task automatic test_deadline();
      chk("R11 clean before starvation", int'(refresh_err), 0);
      row_open(8'h10);
      repeat (5000) @(negedge clk);
      chk("R11 starvation flagged", int'(refresh_err), 1);
      row_close();
      repeat (400) @(negedge clk);
      chk("R11 flag sticky after catch-up", int'(refresh_err), 1);
      do_reset();
      @(negedge clk);
      test_reset_state();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      test_reset_state();
      test_refresh_lap();
      test_basic_access();
      test_row_latch();
      test_page_mode();
      test_bad_order();
      test_refresh_stall();
      test_deferral();
      test_retention();
      test_deadline();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog (all requirements): got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule